// File: doc/BRIEF.md
# Dual-Edge Input Capture Channel

This block timestamps transitions on one asynchronous input pin. It watches a free-running down-counter that lives outside the block. The pin is first brought into the clock domain. It can then be inverted, and its transitions are classified as rising or falling. At each classified edge the block copies the counter value into a holding register kept for that edge direction. It also raises a sticky marker for that direction and, if that direction is enabled for interrupts, raises a shared interrupt flag.

Software drives the block through a flat four-word register port. Writes are synchronous and reads are combinational. The sticky markers and the interrupt flag are cleared by writing ones to them. One master enable gates capture and masks the interrupt line. Software can therefore pause the channel without losing the values it has already captured.

Top module: `edge_capture_chan`

## Requirements
- R1: After reset, every register reads zero and `irq` is low.
- R2: While capture is on, a rising edge stores `cnt_val` into the rising holding word at address 2. The stored value is the one present just before the third clock edge after the pin change, and status bit 0 goes high in the same cycle.
- R3: While capture is on, a falling edge stores `cnt_val` into the falling holding word at address 3 with the same timing, and status bit 1 goes high.
- R4: When control bit 1 (invert) is 1, a physical rise is handled as a falling edge and a physical fall as a rising edge. Changing the invert bit while the pin is idle creates no event.
- R5: The status word (address 1) has bit 0 as the rising marker, bit 1 as the falling marker and bit 2 as the interrupt flag. Writing 1 to a bit clears it, and writing 0 leaves it unchanged.
- R6: The interrupt flag is set by a rising event when control bit 2 is 1, or by a falling event when control bit 3 is 1. An event whose direction is not enabled leaves the flag alone.
- R7: When control bit 0 (capture on) is 0, edges change neither holding word nor any status bit, and `irq` is low. In all cases `irq` equals the interrupt flag ANDed with control bit 0.
- R8: If a hardware set and a write of 1 to the same status bit land in the same cycle, the bit ends up set.
- R9: An input pulse that lasts one clock yields a rising capture and a falling capture on consecutive cycles, with values that differ by one count of the down-counter.
- R10: The control word is at address 0, using bits 3:0 only. It reads back what was written, and higher bits of a write are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | DATA_W | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | DATA_W | Register read data, combinational |
| cnt_val | input | CNT_W | Current value of the external down-counter |
| cap_in | input | 1 | Asynchronous capture pin |
| irq | output | 1 | Capture interrupt |

## Verification
A change on the pin reaches the holding words, the markers, the interrupt flag and `irq` at the third rising clock edge after it. This is two synchronizer stages plus the registered event. A register write takes effect at the first edge, and a read reflects the current state with no delay. The bench model shifts every sampled pin value through a four-deep history. It applies each event at exactly that third edge, using the counter value seen at that edge. Outputs are compared at every falling edge, while the address being read rotates. Directed checks record their expected counter value at the falling edge just before the capturing edge, and read the result at the falling edge just after it.

// File: rtl/edge_capture_chan.sv
module edge_capture_chan #(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic [CNT_W-1:0]  cnt_val,
  input  logic              cap_in,
  output logic              irq
);

  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_STAT = 2'd1;
  localparam logic [1:0] A_RISE = 2'd2;
  localparam logic [1:0] A_FALL = 2'd3;

  logic sync1, sync2, prev;
  logic en_q, inv_q, rie_q, fie_q;
  logic rflag, fflag, iflag;
  logic [CNT_W-1:0] rise_val, fall_val;

  wire up       = ~prev & sync2;
  wire dn       = prev & ~sync2;
  wire rise_evt = en_q & (inv_q ? dn : up);
  wire fall_evt = en_q & (inv_q ? up : dn);
  wire ctrl_wr  = wr_en && (wr_addr == A_CTRL);
  wire stat_wr  = wr_en && (wr_addr == A_STAT);
  wire [2:0] clr = stat_wr ? wr_data[2:0] : 3'b000;

  logic unused_bits;
  assign unused_bits = ^wr_data[DATA_W-1:4];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) {sync1, sync2, prev} <= 3'b000;
    else        {sync1, sync2, prev} <= {cap_in, sync1, sync2};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       {fie_q, rie_q, inv_q, en_q} <= 4'b0000;
    else if (ctrl_wr) {fie_q, rie_q, inv_q, en_q} <= wr_data[3:0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rise_val <= '0;
      fall_val <= '0;
    end else begin
      if (rise_evt) rise_val <= cnt_val;
      if (fall_evt) fall_val <= cnt_val;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rflag <= 1'b0;
      fflag <= 1'b0;
      iflag <= 1'b0;
    end else begin
      rflag <= rise_evt | (rflag & ~clr[0]);
      fflag <= fall_evt | (fflag & ~clr[1]);
      iflag <= (rise_evt & rie_q) | (fall_evt & fie_q) | (iflag & ~clr[2]);
    end

  assign irq = iflag & en_q;

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      A_CTRL:  rd_data[3:0]       = {fie_q, rie_q, inv_q, en_q};
      A_STAT:  rd_data[2:0]       = {iflag, fflag, rflag};
      A_RISE:  rd_data[CNT_W-1:0] = rise_val;
      default: rd_data[CNT_W-1:0] = fall_val;
    endcase
  end

  AST_RISE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    rise_evt |=> (rise_val == $past(cnt_val)) && rflag); // R2

  AST_FALL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    fall_evt |=> (fall_val == $past(cnt_val)) && fflag); // R3

  AST_HOLD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |=> $stable(rise_val) && $stable(fall_val) && !$rose(rflag) && !$rose(fflag)); // R7

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_evt && stat_wr && wr_data[0]) |=> rflag); // R8

  AST_INT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(iflag) |-> $past((rise_evt && rie_q) || (fall_evt && fie_q))); // R6

endmodule

// File: tb/edge_capture_chan_test.sv
`timescale 1ns/1ps
module edge_capture_chan_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = 2'd0;
  logic [31:0] wr_data = '0;
  logic [1:0]  rd_addr = 2'd0;
  logic [31:0] rd_data;
  logic [15:0] cnt_val = 16'hA5A5;
  logic        cap_in = 1'b0;
  logic        irq;

  int n_run = 0, n_fail = 0;
  bit hold = 0;
  logic [1:0] want = 2'd0;

  edge_capture_chan uut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .cnt_val(cnt_val),
    .cap_in(cap_in), .irq(irq));

  always #4 clk = ~clk;
  always @(posedge clk) cnt_val <= cnt_val - 16'd1;

  int h[4] = '{0, 0, 0, 0};
  bit m_en, m_inv, m_rie, m_fie, m_rf, m_ff, m_if;
  int m_rv, m_fv;

  always @(posedge clk) begin
    if (!rst_n) begin
      h = '{0, 0, 0, 0};
      {m_en, m_inv, m_rie, m_fie, m_rf, m_ff, m_if} = '0;
      m_rv = 0; m_fv = 0;
    end else begin
      bit up, dn, re, fe;
      h[3] = h[2]; h[2] = h[1]; h[1] = h[0]; h[0] = cap_in;
      up = (h[3] == 0) && (h[2] == 1);
      dn = (h[3] == 1) && (h[2] == 0);
      re = m_en && (m_inv ? dn : up);
      fe = m_en && (m_inv ? up : dn);
      if (wr_en && wr_addr == 2'd1) begin
        if (wr_data[0]) m_rf = 0;
        if (wr_data[1]) m_ff = 0;
        if (wr_data[2]) m_if = 0;
      end
      if (re) begin m_rf = 1; m_rv = int'(cnt_val); if (m_rie) m_if = 1; end
      if (fe) begin m_ff = 1; m_fv = int'(cnt_val); if (m_fie) m_if = 1; end
      if (wr_en && wr_addr == 2'd0) {m_fie, m_rie, m_inv, m_en} = wr_data[3:0];
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R7 irq", {31'd0, irq}, {31'd0, m_if & m_en});
      case (rd_addr)
        2'd0: chk("R10 ctrl", rd_data, {28'd0, m_fie, m_rie, m_inv, m_en});
        2'd1: chk("R5 status", rd_data, {29'd0, m_if, m_ff, m_rf});
        2'd2: chk("R2 rise word", rd_data, m_rv[31:0]);
        default: chk("R3 fall word", rd_data, m_fv[31:0]);
      endcase
    end
    rd_addr <= hold ? want : rd_addr + 2'd1;
  end

  task automatic peek(logic [1:0] a, logic [31:0] exp, string tag);
    hold = 1; want = a;
    @(negedge clk); #1;
    chk(tag, rd_data, exp);
    hold = 0;
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic edge_cap(logic v, output logic [15:0] e);
    @(negedge clk); cap_in = v;
    @(posedge clk); @(posedge clk);
    @(negedge clk); e = cnt_val;
    @(posedge clk);
  endtask

  task automatic idle(int k);
    repeat (k) @(posedge clk);
  endtask

  initial begin
    repeat (1000000) @(posedge clk);
    n_fail++;
    $display("FAIL R1 watchdog: actual=timeout expected=completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] e, er, ef;
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1;
    peek(0, 0, "R1 ctrl"); peek(1, 0, "R1 status");
    peek(2, 0, "R1 rise"); peek(3, 0, "R1 fall");
    chk("R1 irq", {31'd0, irq}, 32'd0);

    wr(0, 32'h5);
    edge_cap(1, e);
    peek(2, {16'd0, e}, "R2 rise value");
    peek(1, 32'h5, "R5 rise marker");
    chk("R6 irq on rise", {31'd0, irq}, 32'd1);
    wr(1, 0);   peek(1, 32'h5, "R5 write zero");
    wr(1, 1);   peek(1, 32'h4, "R5 clear marker");
    wr(1, 4);   peek(1, 32'h0, "R6 clear flag");
    chk("R6 irq cleared", {31'd0, irq}, 32'd0);

    edge_cap(0, e);
    peek(3, {16'd0, e}, "R3 fall value");
    peek(1, 32'h2, "R6 disabled direction");
    wr(1, 7);

    wr(0, 32'hB);
    idle(4);
    peek(1, 32'h0, "R4 invert toggle quiet");
    edge_cap(1, e);
    peek(3, {16'd0, e}, "R4 inverted rise to fall");
    peek(1, 32'h6, "R4 inverted status");

    wr(0, 0);
    @(negedge clk);
    chk("R7 irq masked", {31'd0, irq}, 32'd0);
    edge_cap(0, ef);
    peek(3, {16'd0, e}, "R7 fall word held");
    peek(1, 32'h6, "R7 status held");

    wr(1, 7);
    wr(0, 1);
    @(negedge clk) cap_in = 0;
    idle(1);
    @(negedge clk) cap_in = 1;
    @(posedge clk); @(posedge clk);
    @(negedge clk); wr_en = 1; wr_addr = 2'd1; wr_data = 32'h1; e = cnt_val;
    @(negedge clk); wr_en = 0;
    peek(1, 32'h1, "R8 set wins");
    peek(2, {16'd0, e}, "R8 value");

    @(negedge clk) cap_in = 0;
    idle(4);
    wr(1, 7);
    @(negedge clk) cap_in = 1;
    @(negedge clk) cap_in = 0;
    @(posedge clk);
    @(negedge clk) er = cnt_val;
    @(posedge clk);
    @(negedge clk) ef = cnt_val;
    @(posedge clk);
    peek(2, {16'd0, er}, "R9 pulse rise");
    peek(3, {16'd0, ef}, "R9 pulse fall");
    chk("R9 one count apart", {16'd0, ef}, {16'd0, er - 16'd1});

    wr(0, 32'hFFFF_FFFA);
    peek(0, 32'hA, "R10 ctrl readback");
    idle(3);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule